// File: doc/BRIEF.md
# Register-Access I2C Target Engine

This block is an I2C target that lives entirely in one system clock domain. It samples the bus clock and data lines as ordinary inputs and passes each through a short synchronizer. It then recognises bus conditions and bit edges from the synchronized levels. It answers one 7-bit address, made of a fixed upper part and three strap inputs. Its job is to turn bus transactions into accesses to a byte-wide register bank that sits beside it.

A write transaction carries a register index and then any number of data bytes. The index loads an internal pointer. Every data byte is acknowledged and handed to the bank as a one-cycle write strobe aimed at that same pointer, because the pointer never advances. A read transaction returns the bank byte at the pointer. The bank supplies that byte combinationally from the pointer output. A dummy write followed by a repeated START therefore reads back the register just named. Repeated START and STOP are reported as separate single-cycle events that belong to the selected transaction. A downstream persistence controller can then tell a committed write (ended by STOP) from a volatile one (ended by repeated START). While the `busy` input is high, for example during a nonvolatile commit, the engine refuses its own address.

The write port is valid-only. A bus without clock stretching cannot be stalled, so there is no ready signal and no back-pressure. The bank must take every `wr_valid` pulse in the cycle it appears. A new strobe can come no sooner than nine bus clocks later. The read side has no handshake: `rd_data` must follow `rd_addr` within the same cycle.

Top module: `i2c_regport_target`

## Requirements
- R1: The engine acknowledges an address byte only when its upper seven bits equal binary 1010 followed by strap[2], strap[1], strap[0], and `busy` is low. Bit 0 of that byte selects the direction, with 0 meaning write and 1 meaning read.
- R2: A START or repeated START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A repeated START or STOP that ends a transaction addressed to this engine produces a one-cycle pulse on `rstart_seen` or `stop_seen`. The same conditions on a foreign transaction produce no pulse.
- R3: Bytes move most significant bit first. The ninth clock of each byte is the acknowledge slot, and a 0 there means ACK.
- R4: After a non-matching address byte, the engine never pulls SDA and emits no write strobe until the next START.
- R5: In a write, the byte after the address byte loads the pointer (visible on `rd_addr`). Every later byte is acknowledged and produces a `wr_valid` pulse carrying `wr_addr` equal to the pointer and `wr_data` equal to the byte.
- R6: Successive data bytes in one write all target the same register, so the last byte is what the register holds afterwards.
- R7: A read returns `rd_data` at the current pointer. A read with no register index uses the pointer left by an earlier transaction. A dummy write, then a repeated START, then a read returns the register just indexed.
- R8: During a read, SDA changes only after SCL falls and stays stable while SCL is high. When the controller NACKs, the engine releases SDA.
- R9: While `busy` is high, the own address is NACKed and the rest of that transaction has no effect on the register bank.
- R10: After reset, `sda_oe` is low, no strobe is active and the pointer is 0. `sda_oe` is the only SDA drive and means "pull low", and `wr_valid` is never high for two cycles in a row.
- R11: When the controller ACKs a read byte, the next byte comes from the same pointer. The pointer does not advance on reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | High pulls SDA low; low releases it |
| strap | input | 3 | Low address bits, strap[2] most significant |
| busy | input | 1 | High refuses the own address |
| wr_valid | output | 1 | One-cycle write strobe to the register bank |
| wr_addr | output | 8 | Register index for the write strobe |
| wr_data | output | 8 | Byte for the write strobe |
| stop_seen | output | 1 | One-cycle pulse: STOP ended a selected transaction |
| rstart_seen | output | 1 | One-cycle pulse: repeated START inside a selected transaction |
| rd_addr | output | 8 | Current pointer, the register index to read |
| rd_data | input | 8 | Bank byte at `rd_addr`, same cycle |

## Verification
The hardest situation to reach from the ports is a dummy write turned into a read by a repeated START and then continued with controller ACKs. This sequence must keep the pointer fixed while the engine alternates between driving data bits and sampling the controller's acknowledge. The bench builds it from a bit-level open-drain bus model. It composes START, byte, acknowledge and repeated START steps, and samples SDA at both ends of every high phase to prove stability. The address comparator is swept over every strap setting against every low-address pattern. Busy refusal and foreign-address traffic are driven with bytes that would otherwise be accepted, and the bench confirms at the ports that nothing reaches the bank.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_REGA,
    ST_RACKW,
    ST_WDATA,
    ST_DACK,
    ST_RDATA,
    ST_MACK,
    ST_IGNORE
  } tgt_state_e;
endpackage

// File: rtl/i2c_line_cond.sv
module i2c_line_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);
  localparam int LINES = 2;
  localparam int TOP   = SYNC_STAGES - 1;

  logic [LINES-1:0]       raw;
  logic [SYNC_STAGES-1:0] pipe [LINES];
  logic [LINES-1:0]       lvl, lvl_q;

  assign raw = {sda_in, scl_in};

  for (genvar g = 0; g < LINES; g++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[g] <= '1;
      else        pipe[g] <= {pipe[g][SYNC_STAGES-2:0], raw[g]};
    end
    assign lvl[g] = pipe[g][TOP];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '1;
    else        lvl_q <= lvl;
  end

  assign scl_lvl  = lvl[0];
  assign sda_lvl  = lvl[1];
  assign scl_rise = lvl[0] & ~lvl_q[0];
  assign scl_fall = ~lvl[0] & lvl_q[0];
  assign start_c  = lvl[0] & lvl_q[0] & lvl_q[1] & ~lvl[1];
  assign stop_c   = lvl[0] & lvl_q[0] & ~lvl_q[1] & lvl[1];

  // R2
  cond_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_c, stop_c, scl_rise, scl_fall}));
endmodule

// File: rtl/i2c_target_ctl.sv
module i2c_target_ctl
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] BASE_ADDR = 7'h50,
  parameter int         STRAP_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_lvl,
  input  logic               sda_lvl,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_c,
  input  logic               stop_c,
  input  logic [STRAP_W-1:0] strap,
  input  logic               busy,
  input  logic [BYTE_W-1:0]  rd_byte,
  output logic               sda_pull,
  output logic               ptr_load,
  output logic               data_wr,
  output logic [BYTE_W-1:0]  byte_q,
  output logic               rs_pulse,
  output logic               sp_pulse
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  tgt_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic              selected_q;
  logic              rnw_q;
  logic              mack_q;
  logic              addr_hit;

  assign addr_hit = (sh_q[BYTE_W-1:1] == {BASE_ADDR[6:STRAP_W], strap});
  assign byte_q   = sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      sh_q       <= '0;
      selected_q <= 1'b0;
      rnw_q      <= 1'b0;
      mack_q     <= 1'b0;
      sda_pull   <= 1'b0;
      ptr_load   <= 1'b0;
      data_wr    <= 1'b0;
      rs_pulse   <= 1'b0;
      sp_pulse   <= 1'b0;
    end else begin
      ptr_load <= 1'b0;
      data_wr  <= 1'b0;
      rs_pulse <= 1'b0;
      sp_pulse <= 1'b0;
      if (stop_c) begin
        state_q    <= ST_IDLE;
        sda_pull   <= 1'b0;
        sp_pulse   <= selected_q;
        selected_q <= 1'b0;
      end else if (start_c) begin
        state_q    <= ST_ADDR;
        cnt_q      <= '0;
        sda_pull   <= 1'b0;
        rs_pulse   <= selected_q;
        selected_q <= 1'b0;
      end else begin
        case (state_q)
          ST_ADDR, ST_REGA, ST_WDATA: begin
            if (scl_rise && cnt_q < FULL) begin
              sh_q  <= {sh_q[BYTE_W-2:0], sda_lvl};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall && cnt_q == FULL) begin
              cnt_q <= '0;
              if (state_q == ST_ADDR) begin
                if (addr_hit && !busy) begin
                  state_q    <= ST_AACK;
                  sda_pull   <= 1'b1;
                  selected_q <= 1'b1;
                  rnw_q      <= sh_q[0];
                end else begin
                  state_q <= ST_IGNORE;
                end
              end else if (state_q == ST_REGA) begin
                state_q  <= ST_RACKW;
                sda_pull <= 1'b1;
                ptr_load <= 1'b1;
              end else begin
                state_q  <= ST_DACK;
                sda_pull <= 1'b1;
                data_wr  <= 1'b1;
              end
            end
          end
          ST_AACK, ST_RACKW, ST_DACK: begin
            if (scl_fall) begin
              cnt_q <= '0;
              if (state_q == ST_AACK && rnw_q) begin
                state_q  <= ST_RDATA;
                sh_q     <= rd_byte;
                sda_pull <= ~rd_byte[BYTE_W-1];
              end else begin
                state_q  <= (state_q == ST_AACK) ? ST_REGA : ST_WDATA;
                sda_pull <= 1'b0;
              end
            end
          end
          ST_RDATA: begin
            if (scl_rise) begin
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall) begin
              if (cnt_q == FULL) begin
                state_q  <= ST_MACK;
                sda_pull <= 1'b0;
              end else begin
                sh_q     <= {sh_q[BYTE_W-2:0], 1'b0};
                sda_pull <= ~sh_q[BYTE_W-2];
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              mack_q <= ~sda_lvl;
            end else if (scl_fall) begin
              cnt_q <= '0;
              if (mack_q) begin
                state_q  <= ST_RDATA;
                sh_q     <= rd_byte;
                sda_pull <= ~rd_byte[BYTE_W-1];
              end else begin
                state_q <= ST_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R4
  ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IGNORE) |-> !sda_pull);

  // R8
  drive_change_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull != $past(sda_pull) && !$past(start_c) && !$past(stop_c)) |-> !scl_lvl);

  // R9
  busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_pull) && state_q == ST_AACK) |-> !$past(busy));

  // R2
  bus_cond_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(start_c) || $past(stop_c)) |-> !sda_pull);
endmodule

// File: rtl/i2c_ptr_unit.sv
module i2c_ptr_unit
  import i2c_tgt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_load,
  input  logic              data_wr,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [BYTE_W-1:0] ptr_o,
  output logic              wr_valid,
  output logic [BYTE_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_o    <= '0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_valid <= data_wr;
      if (ptr_load) ptr_o <= byte_in;
      if (data_wr) begin
        wr_addr <= ptr_o;
        wr_data <= byte_in;
      end
    end
  end

  // R10
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  // R6
  ptr_hold_on_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $stable(ptr_o));
endmodule

// File: rtl/i2c_regport_target.sv
module i2c_regport_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] BASE_ADDR   = 7'h50,
  parameter int         STRAP_W     = 3,
  parameter int         SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  input  logic [STRAP_W-1:0] strap,
  input  logic               busy,
  output logic               wr_valid,
  output logic [BYTE_W-1:0]  wr_addr,
  output logic [BYTE_W-1:0]  wr_data,
  output logic               stop_seen,
  output logic               rstart_seen,
  output logic [BYTE_W-1:0]  rd_addr,
  input  logic [BYTE_W-1:0]  rd_data
);
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_c, stop_c;
  logic ptr_load, data_wr;
  logic [BYTE_W-1:0] byte_q;

  i2c_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_in   (scl_i),
    .sda_in   (sda_i),
    .scl_lvl  (scl_lvl),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_c  (start_c),
    .stop_c   (stop_c)
  );

  i2c_target_ctl #(.BASE_ADDR(BASE_ADDR), .STRAP_W(STRAP_W)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_lvl  (scl_lvl),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_c  (start_c),
    .stop_c   (stop_c),
    .strap    (strap),
    .busy     (busy),
    .rd_byte  (rd_data),
    .sda_pull (sda_oe),
    .ptr_load (ptr_load),
    .data_wr  (data_wr),
    .byte_q   (byte_q),
    .rs_pulse (rstart_seen),
    .sp_pulse (stop_seen)
  );

  i2c_ptr_unit u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .ptr_load (ptr_load),
    .data_wr  (data_wr),
    .byte_in  (byte_q),
    .ptr_o    (rd_addr),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
  );

  // R2
  event_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(stop_seen && rstart_seen));
endmodule

// File: tb/sim_i2c_regport_target.sv
module sim_i2c_regport_target;
  localparam int Q = 10;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [2:0] strap = 3'd0;
  logic       busy  = 1'b0;
  logic       sda_oe, wr_valid, stop_seen, rstart_seen;
  logic [7:0] wr_addr, wr_data, rd_addr, rd_data;
  logic       sda_bus;
  logic [7:0] bank [256];

  assign sda_bus = sda_m & ~sda_oe;
  assign rd_data = bank[rd_addr];

  i2c_regport_target u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .strap(strap), .busy(busy), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .stop_seen(stop_seen), .rstart_seen(rstart_seen),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 73 + 17) & 255);
  endfunction

  int vectors = 0, errs = 0;
  int wr_cnt = 0, wrong_addr = 0, stop_cnt = 0, rs_cnt = 0, oe_cnt = 0, long_pulse = 0;
  logic [7:0] exp_waddr = 8'd0;
  logic wv_d = 1'b0, rs_d = 1'b0, sp_d = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) bank[i] <= pat(i);
    end else if (wr_valid) begin
      bank[wr_addr] <= wr_data;
    end
  end

  always @(posedge clk) begin
    if (rst_n) begin
      if (wr_valid) begin
        wr_cnt++;
        if (wr_addr != exp_waddr) wrong_addr++;
      end
      if (stop_seen) stop_cnt++;
      if (rstart_seen) rs_cnt++;
      if (sda_oe) oe_cnt++;
      if ((wr_valid && wv_d) || (rstart_seen && rs_d) || (stop_seen && sp_d)) long_pulse++;
    end
    wv_d <= wr_valid;
    rs_d <= rstart_seen;
    sp_d <= stop_seen;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic wbyte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      scl_m = 1'b1; tick(Q);
      scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q / 2);
    ack = !sda_bus; tick(Q / 2);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic rbyte(input bit nack, output logic [7:0] d, output int unstable);
    logic b0, b1;
    unstable = 0;
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(2);
      b0 = sda_bus; tick(Q - 4);
      b1 = sda_bus; tick(2);
      scl_m = 1'b0; tick(Q);
      d[i] = b0;
      if (b0 != b1) unstable++;
    end
    sda_m = nack; tick(Q);
    scl_m = 1'b1; tick(Q);
    scl_m = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  task automatic run_all();
    bit a0, a1, a2, ok;
    logic [7:0] d, d1, d2, d3, reg_i;
    int un, un1, un2, w0, s0, r0, o0;

    tick(5); rst_n = 1'b1; tick(5);
    chk(sda_oe == 1'b0, "R10 reset sda_oe", sda_oe, 0);
    chk(wr_valid == 1'b0, "R10 reset wr_valid", wr_valid, 0);
    chk(rd_addr == 8'd0, "R10 reset pointer", rd_addr, 0);

    // R1: every strap value against every low-address pattern
    for (int s = 0; s < 8; s++) begin
      strap = 3'(s); tick(4);
      for (int a = 0; a < 8; a++) begin
        bus_start();
        wbyte({4'hA, 3'(a), 1'b0}, a0);
        bus_stop();
        chk(a0 == (a == s), "R1 address match sweep", a0, a == s);
      end
    end
    strap = 3'd3; tick(4);
    bus_start(); wbyte({4'hB, 3'd3, 1'b0}, a0); bus_stop();
    chk(!a0, "R1 wrong fixed bits", a0, 0);

    strap = 3'd5; tick(4);   // own write byte 0xAA, read byte 0xAB

    // R5 R6: index then three data bytes
    for (int k = 0; k < 8; k++) begin
      reg_i = 8'(k * 32 + 3);
      exp_waddr = reg_i;
      w0 = wr_cnt; s0 = stop_cnt; ok = 1'b1;
      bus_start();
      wbyte(8'hAA, a0); ok &= a0;
      wbyte(reg_i, a0); ok &= a0;
      for (int j = 0; j < 3; j++) begin
        d = 8'(k * 7 + j * 29 + 1);
        wbyte(d, a0); ok &= a0;
      end
      bus_stop(); tick(4);
      chk(ok, "R5 all write bytes acked", ok, 1);
      chk(wr_cnt - w0 == 3, "R5 one strobe per data byte", wr_cnt - w0, 3);
      chk(bank[reg_i] == 8'(k * 7 + 2 * 29 + 1), "R6 last byte kept", bank[reg_i], 8'(k * 7 + 59));
      chk(stop_cnt - s0 == 1, "R2 stop reported", stop_cnt - s0, 1);
      chk(rd_addr == reg_i, "R5 pointer loaded", rd_addr, reg_i);
    end
    chk(wrong_addr == 0, "R6 strobes stay on one register", wrong_addr, 0);

    // R7: dummy write, repeated START, read
    for (int k = 0; k < 8; k++) begin
      reg_i = 8'(k * 29 + 100);
      w0 = wr_cnt; r0 = rs_cnt;
      bus_start();
      wbyte(8'hAA, a0);
      wbyte(reg_i, a1);
      bus_start();
      wbyte(8'hAB, a2);
      rbyte(1'b1, d, un);
      tick(3);
      chk(sda_oe == 1'b0, "R8 release after controller NACK", sda_oe, 0);
      bus_stop(); tick(4);
      chk(a0 && a1 && a2, "R7 dummy write and read acked", {a0, a1, a2}, 7);
      chk(d == pat(reg_i), "R7 read after repeated START", d, pat(reg_i));
      chk(rs_cnt - r0 == 1, "R2 repeated START reported", rs_cnt - r0, 1);
      chk(un == 0, "R8 data stable while SCL high", un, 0);
      chk(wr_cnt == w0, "R5 no strobe without data byte", wr_cnt - w0, 0);
    end

    // R7: read with no index uses pointer 47 from the last dummy write
    bus_start(); wbyte(8'hAB, a0); rbyte(1'b1, d, un); bus_stop();
    chk(d == pat(47), "R7 read at current pointer", d, pat(47));
    chk(rd_addr == 8'd47, "R7 pointer unchanged by read", rd_addr, 47);

    // R11: continued read stays on the same register
    bus_start(); wbyte(8'hAB, a0);
    rbyte(1'b0, d1, un); rbyte(1'b0, d2, un1); rbyte(1'b1, d3, un2);
    bus_stop();
    chk(d1 == pat(47) && d2 == pat(47) && d3 == pat(47), "R11 repeated read same register",
        {d1, d2, d3}, {pat(47), pat(47), pat(47)});
    chk(un + un1 + un2 == 0, "R8 stable bits on continued read", un + un1 + un2, 0);

    // R3: bit order through write and read
    exp_waddr = 8'h40;
    bus_start(); wbyte(8'hAA, a0); wbyte(8'h40, a0); wbyte(8'h01, a0); bus_stop(); tick(4);
    chk(bank[8'h40] == 8'h01, "R3 MSB-first write", bank[8'h40], 1);
    bus_start(); wbyte(8'hAA, a0); wbyte(8'h40, a0); bus_start(); wbyte(8'hAB, a0);
    rbyte(1'b1, d, un); bus_stop();
    chk(d == 8'h01, "R3 MSB-first read", d, 1);

    // R4: foreign address, then bytes that would look valid
    o0 = oe_cnt; w0 = wr_cnt; s0 = stop_cnt;
    bus_start(); wbyte(8'hA8, a0);
    wbyte(8'hAA, a1); wbyte(8'h10, a2); wbyte(8'h55, ok);
    bus_stop(); tick(4);
    chk(!a0 && !a1 && !a2 && !ok, "R4 no acknowledge while ignoring", {a0, a1, a2, ok}, 0);
    chk(oe_cnt == o0, "R4 SDA never pulled", oe_cnt - o0, 0);
    chk(wr_cnt == w0, "R4 no write strobe", wr_cnt - w0, 0);
    chk(stop_cnt == s0, "R2 foreign STOP not reported", stop_cnt - s0, 0);

    // R9: busy refuses the own address
    busy = 1'b1; w0 = wr_cnt;
    bus_start(); wbyte(8'hAA, a0); wbyte(8'h20, a1); wbyte(8'h77, a2); bus_stop(); tick(4);
    chk(!a0, "R9 address NACK while busy", a0, 0);
    chk(wr_cnt == w0 && bank[8'h20] == pat(32), "R9 bank untouched", bank[8'h20], pat(32));
    busy = 1'b0; exp_waddr = 8'h20;
    bus_start(); wbyte(8'hAA, a0); wbyte(8'h20, a1); wbyte(8'h77, a2); bus_stop(); tick(4);
    chk(a0 && bank[8'h20] == 8'h77, "R9 accepted once busy clears", bank[8'h20], 8'h77);

    chk(long_pulse == 0, "R10 single-cycle strobes", long_pulse, 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (190000) @(posedge clk);
        errs++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule